// File: doc/BRIEF.md
# Display DMA Next-Descriptor Selection with One-Shot Branch

This block decides, for each channel of a two-channel display DMA engine, where the next descriptor is fetched from once a frame completes. Each channel has two registers. One holds the normal next-descriptor address. The other is a branch register, in which software can post a one-shot request to redirect the chain to a different descriptor. The frame-done handshake covers every kind of transfer the channel performs, frame pixels as well as palette loads, and the branch decision is made the same way for both.

When a channel reports the end of a frame, the block raises a fetch request with a 16-byte aligned address. That address comes from the branch target if a branch was requested, and from the normal register otherwise. The request stays up until the memory side reports that the descriptor has been loaded. A taken branch then clears its own request bit. If the branch register also enabled notification, a sticky status bit for that channel is set, and the interrupt output follows the OR of the status bits. When both channels drive a two-panel display, software must post the branch on both channels. Each channel still branches on its own at its own frame end.

Top module: `dchain_branch_ctrl`

## Requirements
- R1: After reset, every register reads zero, no fetch request is raised and irq is low.
- R2: The register map is: word 2c is the normal next-descriptor register of channel c, word 2c+1 is the branch register of channel c, and word 4 is the status register. The branch register holds the target in bits 31:4, the notify enable in bit 1 and the branch request in bit 0. Bits 3:2 ignore writes and read as zero.
- R3: With no branch requested, fetch_req of the channel is high one cycle after frame_done. Its fetch address is the next-descriptor register bits 31:4 followed by four zero bits. Bits 3:0 of that register ignore writes and read as zero.
- R4: With the branch request set when frame_done is seen, the fetch address is the branch target bits 31:4 followed by four zero bits, and the normal next-descriptor register is ignored.
- R5: fetch_req stays high with a stable address until desc_loaded is seen, and it is low in the following cycle.
- R6: The branch request bit reads zero one cycle after desc_loaded ends a branch fetch. It is left unchanged by the load of a non-branch fetch.
- R7: A taken branch with notify enable set sets status bit 2+c of channel c after desc_loaded, and does not set it while the fetch is still pending. With notify enable clear, the status bit is not set.
- R8: Status bits are sticky and are cleared by writing one to them at word 4. A set and a clear of the same bit in the same cycle leave it set. irq is high exactly when any status bit is set.
- R9: A software write to the branch register in the same cycle that hardware clears the request bit takes effect in full, so the new request is kept.
- R10: The channels are independent. Frame-done and load events on one channel leave the other channel's fetch, branch request and status unchanged.
- R11: A branch request written while a fetch is pending does not change that fetch. It applies at the next frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| frame_done | input | 2 | Per-channel end-of-frame pulse |
| desc_loaded | input | 2 | Per-channel descriptor-loaded pulse |
| fetch_req | output | 2 | Per-channel descriptor fetch request |
| fetch_addr | output | 64 | Per-channel fetch address, channel c in bits 32c+31:32c |
| irq | output | 1 | OR of sticky branch status bits |

## Verification
The branch decision is latched at the frame-done edge. A wrong latched decision or target therefore shows up on fetch_addr in the very next cycle, while fetch_req is high, and stays visible until the load. A request bit that hardware fails to clear, or clears when it should not, can be seen by reading the branch register one cycle after desc_loaded. It also makes the following frame end fetch from the wrong address. A notify flag captured wrongly shows up on irq and on status word 4 one cycle after the load, and an early setting would already show while the fetch is pending.

// File: rtl/dcb_pkg.sv
// Shared constants and types for the descriptor branch controller.
// Assumes descriptors are aligned to 16 bytes (four zero low address bits).
package dcb_pkg;
    localparam int ALIGN_BITS  = 4;
    localparam int BR_REQ_BIT  = 0;
    localparam int BR_IE_BIT   = 1;
    localparam int ST_BIT_BASE = 2;

    typedef enum logic {
        CH_RUN   = 1'b0,
        CH_FETCH = 1'b1
    } ch_state_e;
endpackage

// File: rtl/dcb_branch_reg.sv
// Per-channel branch register: target field, notify enable and one-shot
// request. Software writes take priority over the hardware clear of the
// request. Assumes the caller has already sliced the write data into fields.
module dcb_branch_reg #(
    parameter int ADDR_W = 32,
    localparam int TGT_W = ADDR_W - dcb_pkg::ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [TGT_W-1:0]  sw_tgt,
    input  logic              sw_ie,
    input  logic              sw_req,
    input  logic              hw_clr,
    output logic [TGT_W-1:0]  tgt,
    output logic              ie,
    output logic              req,
    output logic [ADDR_W-1:0] rd_word
);
    // Hold the fields; a software write overrides the hardware clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt <= '0;
            ie  <= 1'b0;
            req <= 1'b0;
        end else if (sw_we) begin
            tgt <= sw_tgt;
            ie  <= sw_ie;
            req <= sw_req;
        end else if (hw_clr) begin
            req <= 1'b0;
        end
    end

    // Present the fields in register layout, reserved bits as zero.
    always_comb begin
        rd_word = {tgt, 2'b00, ie, req};
    end

    assert_sw_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (req == $past(sw_req)) && (tgt == $past(sw_tgt)));

    assert_hw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr && !sw_we) |=> !req);
endmodule

// File: rtl/dcb_chan_seq.sv
// Per-channel sequencer: holds the normal next-descriptor address, latches
// the branch decision at frame end, and holds a fetch request until the
// descriptor is loaded. Assumes frame_done does not arrive while a fetch is
// pending; such a pulse is ignored.
module dcb_chan_seq #(
    parameter int ADDR_W = 32,
    localparam int TGT_W = ADDR_W - dcb_pkg::ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nd_we,
    input  logic [TGT_W-1:0]  nd_wtgt,
    input  logic [TGT_W-1:0]  br_tgt,
    input  logic              br_ie,
    input  logic              br_req,
    input  logic              frame_done,
    input  logic              desc_loaded,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] nd_rd_word,
    output logic              hw_clr,
    output logic              st_set
);
    import dcb_pkg::*;

    ch_state_e        state;
    logic [TGT_W-1:0] nd_q;
    logic [TGT_W-1:0] addr_q;
    logic             taken_q;
    logic             ie_q;

    // Normal next-descriptor register, software writable only.
    always_ff @(posedge clk) begin
        if (!rst_n)     nd_q <= '0;
        else if (nd_we) nd_q <= nd_wtgt;
    end

    // Latch the branch decision at frame end and wait for the load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= CH_RUN;
            addr_q  <= '0;
            taken_q <= 1'b0;
            ie_q    <= 1'b0;
        end else begin
            case (state)
                CH_RUN: if (frame_done) begin
                    state   <= CH_FETCH;
                    taken_q <= br_req;
                    ie_q    <= br_ie;
                    addr_q  <= br_req ? br_tgt : nd_q;
                end
                CH_FETCH: if (desc_loaded) state <= CH_RUN;
                default: state <= CH_RUN;
            endcase
        end
    end

    // Drive the fetch port and the end-of-branch events.
    always_comb begin
        fetch_req  = (state == CH_FETCH);
        fetch_addr = {addr_q, {ALIGN_BITS{1'b0}}};
        nd_rd_word = {nd_q, {ALIGN_BITS{1'b0}}};
        hw_clr     = fetch_req && desc_loaded && taken_q;
        st_set     = hw_clr && ie_q;
    end

    assert_fetch_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req) |-> $past(frame_done));

    assert_fetch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !desc_loaded) |=> fetch_req && $stable(fetch_addr));

    assert_fetch_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && desc_loaded) |=> !fetch_req);
endmodule

// File: rtl/dcb_status.sv
// Sticky per-channel branch status bits with write-one-to-clear and a
// combined interrupt. A set in the same cycle as a clear wins.
module dcb_status #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] st,
    output logic              irq
);
    // Update the sticky bits: clear first, then apply sets.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= '0;
        else        st <= (st & ~(clr_mask & {NUM_CH{clr_we}})) | set;
    end

    // Interrupt is high while any status bit is set.
    always_comb begin
        irq = |st;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_sticky_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> st[i]);

        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!set[i] && !(clr_we && clr_mask[i])) |=> st[i] == $past(st[i]));
    end
endmodule

// File: rtl/dchain_branch_ctrl.sv
// Top of the descriptor chaining and branch control block. Decodes the
// register port, instantiates one branch register and one sequencer per
// channel, and collects the status bits. Assumes the default register
// word index width covers 2*NUM_CH+1 words.
module dchain_branch_ctrl #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 32,
    parameter int RA_W   = $clog2(2 * NUM_CH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [RA_W-1:0]          reg_addr,
    input  logic [ADDR_W-1:0]        reg_wdata,
    output logic [ADDR_W-1:0]        reg_rdata,
    input  logic [NUM_CH-1:0]        frame_done,
    input  logic [NUM_CH-1:0]        desc_loaded,
    output logic [NUM_CH-1:0]        fetch_req,
    output logic [NUM_CH*ADDR_W-1:0] fetch_addr,
    output logic                     irq
);
    import dcb_pkg::*;

    localparam int TGT_W  = ADDR_W - ALIGN_BITS;
    localparam int ST_IDX = 2 * NUM_CH;

    logic [NUM_CH-1:0] hw_clr;
    logic [NUM_CH-1:0] st_set;
    logic [NUM_CH-1:0] st;
    logic [TGT_W-1:0]  br_tgt [NUM_CH];
    logic [NUM_CH-1:0] br_ie;
    logic [NUM_CH-1:0] br_req;
    logic [ADDR_W-1:0] nd_rd  [NUM_CH];
    logic [ADDR_W-1:0] br_rd  [NUM_CH];
    logic              st_we;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic nd_we;
        logic br_we;

        // Decode this channel's two register words.
        always_comb begin
            nd_we = reg_we && (reg_addr == RA_W'(2 * c));
            br_we = reg_we && (reg_addr == RA_W'(2 * c + 1));
        end

        dcb_branch_reg #(.ADDR_W(ADDR_W)) u_br (
            .clk     (clk),
            .rst_n   (rst_n),
            .sw_we   (br_we),
            .sw_tgt  (reg_wdata[ADDR_W-1:ALIGN_BITS]),
            .sw_ie   (reg_wdata[BR_IE_BIT]),
            .sw_req  (reg_wdata[BR_REQ_BIT]),
            .hw_clr  (hw_clr[c]),
            .tgt     (br_tgt[c]),
            .ie      (br_ie[c]),
            .req     (br_req[c]),
            .rd_word (br_rd[c])
        );

        dcb_chan_seq #(.ADDR_W(ADDR_W)) u_seq (
            .clk         (clk),
            .rst_n       (rst_n),
            .nd_we       (nd_we),
            .nd_wtgt     (reg_wdata[ADDR_W-1:ALIGN_BITS]),
            .br_tgt      (br_tgt[c]),
            .br_ie       (br_ie[c]),
            .br_req      (br_req[c]),
            .frame_done  (frame_done[c]),
            .desc_loaded (desc_loaded[c]),
            .fetch_req   (fetch_req[c]),
            .fetch_addr  (fetch_addr[c*ADDR_W +: ADDR_W]),
            .nd_rd_word  (nd_rd[c]),
            .hw_clr      (hw_clr[c]),
            .st_set      (st_set[c])
        );
    end

    // Status word write strobe.
    always_comb begin
        st_we = reg_we && (reg_addr == RA_W'(ST_IDX));
    end

    dcb_status #(.NUM_CH(NUM_CH)) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (st_set),
        .clr_we   (st_we),
        .clr_mask (reg_wdata[ST_BIT_BASE +: NUM_CH]),
        .st       (st),
        .irq      (irq)
    );

    // Combinational read mux over all register words.
    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == RA_W'(2 * c))     reg_rdata = nd_rd[c];
            if (reg_addr == RA_W'(2 * c + 1)) reg_rdata = br_rd[c];
        end
        if (reg_addr == RA_W'(ST_IDX)) reg_rdata = ADDR_W'({st, {ST_BIT_BASE{1'b0}}});
    end

    assert_irq_follows_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|(desc_loaded & fetch_req)));
endmodule

// File: tb/tb_dchain_branch_ctrl.sv
module tb_dchain_branch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  frame_done = '0;
    logic [1:0]  desc_loaded = '0;
    logic [1:0]  fetch_req;
    logic [63:0] fetch_addr;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dchain_branch_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_done(frame_done),
        .desc_loaded(desc_loaded), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .irq(irq)
    );

    typedef struct packed {
        logic        ch;
        logic [31:0] nxt;
        logic [31:0] brw;
        logic [31:0] exp_addr;
        logic        exp_st;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 32'h1000_0040, 32'h0000_0000, 32'h1000_0040, 1'b0},
        '{1'b0, 32'h1000_0040, 32'h2000_0081, 32'h2000_0080, 1'b0},
        '{1'b0, 32'h1000_0040, 32'h2000_0083, 32'h2000_0080, 1'b1},
        '{1'b1, 32'h3000_0105, 32'h0000_0002, 32'h3000_0100, 1'b0},
        '{1'b1, 32'h3000_0100, 32'hFFFF_FFF3, 32'hFFFF_FFF0, 1'b1},
        '{1'b1, 32'hABCD_EF0F, 32'h5555_555F, 32'h5555_5550, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic frame_end(input int ch);
        @(negedge clk);
        frame_done[ch] = 1'b1;
        @(negedge clk);
        frame_done = '0;
    endtask

    task automatic load(input int ch);
        @(negedge clk);
        desc_loaded[ch] = 1'b1;
        @(negedge clk);
        desc_loaded = '0;
    endtask

    function automatic logic [31:0] faddr(input int ch);
        return fetch_addr[ch*32 +: 32];
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register and output
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R1 reg", d, 32'h0);
        end
        chk("R1 fetch_req", {30'h0, fetch_req}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // Vector table: R2, R3, R4, R5, R6, R7
        for (int i = 0; i < 6; i++) begin
            int ch;
            ch = int'(VECS[i].ch);
            wr(3'd4, 32'h0000_000C);
            wr(3'(2 * ch), VECS[i].nxt);
            wr(3'(2 * ch + 1), VECS[i].brw);
            rd(3'(2 * ch + 1), d);
            chk("R2 branch readback", d, VECS[i].brw & 32'hFFFF_FFF3);
            rd(3'(2 * ch), d);
            chk("R3 next readback", d, VECS[i].nxt & 32'hFFFF_FFF0);
            frame_end(ch);
            chk("R3 fetch_req raised", {31'h0, fetch_req[ch]}, 32'h1);
            chk("R4 fetch address", faddr(ch), VECS[i].exp_addr);
            load(ch);
            chk("R5 fetch_req released", {31'h0, fetch_req[ch]}, 32'h0);
            rd(3'(2 * ch + 1), d);
            chk("R6 request bit after load", {31'h0, d[0]}, 32'h0);
            rd(3'd4, d);
            chk("R7 status bit", {31'h0, d[2 + ch]}, {31'h0, VECS[i].exp_st});
            chk("R8 irq", {31'h0, irq}, {31'h0, VECS[i].exp_st});
        end

        // R7 and R5: status not set while pending, address held
        wr(3'd4, 32'h0000_000C);
        wr(3'd1, 32'h0000_0403);
        frame_end(0);
        a0 = faddr(0);
        chk("R4 target 0x400", a0, 32'h0000_0400);
        repeat (3) @(negedge clk);
        rd(3'd4, d);
        chk("R7 no status while pending", d, 32'h0);
        chk("R5 request held", {31'h0, fetch_req[0]}, 32'h1);
        chk("R5 address stable", faddr(0), a0);
        load(0);
        rd(3'd4, d);
        chk("R7 status after load", d, 32'h0000_0004);

        // R8: clearing the other channel's bit leaves this one set
        wr(3'd4, 32'h0000_0008);
        rd(3'd4, d);
        chk("R8 sticky", d, 32'h0000_0004);
        wr(3'd4, 32'h0000_0004);
        rd(3'd4, d);
        chk("R8 write one clears", d, 32'h0);
        chk("R8 irq low", {31'h0, irq}, 32'h0);

        // R8: set and clear of the same bit in one cycle leaves it set
        wr(3'd1, 32'h0000_0503);
        frame_end(0);
        @(negedge clk);
        desc_loaded[0] = 1'b1;
        reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h0000_0004;
        @(negedge clk);
        desc_loaded = '0; reg_we = 1'b0;
        rd(3'd4, d);
        chk("R8 set wins over clear", d, 32'h0000_0004);
        wr(3'd4, 32'h0000_000C);

        // R9: software write in the hardware-clear cycle is kept
        wr(3'd3, 32'h0000_0101);
        frame_end(1);
        chk("R4 ch1 target 0x100", faddr(1), 32'h0000_0100);
        @(negedge clk);
        desc_loaded[1] = 1'b1;
        reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h0000_0201;
        @(negedge clk);
        desc_loaded = '0; reg_we = 1'b0;
        rd(3'd3, d);
        chk("R9 new request kept", d, 32'h0000_0201);
        frame_end(1);
        chk("R9 new target used", faddr(1), 32'h0000_0200);
        load(1);

        // R11: request written during a normal fetch applies next frame
        wr(3'd0, 32'h0000_0700);
        wr(3'd1, 32'h0000_0000);
        frame_end(0);
        chk("R3 normal address", faddr(0), 32'h0000_0700);
        wr(3'd1, 32'h0000_0901);
        chk("R11 pending fetch unchanged", faddr(0), 32'h0000_0700);
        load(0);
        rd(3'd1, d);
        chk("R6 not cleared by normal load", d, 32'h0000_0901);
        frame_end(0);
        chk("R11 branch at next frame", faddr(0), 32'h0000_0900);
        load(0);
        rd(3'd1, d);
        chk("R6 cleared after branch", d, 32'h0000_0900);

        // R10: both channels end frames together, loads separately
        wr(3'd1, 32'h0000_0A01);
        wr(3'd2, 32'h0000_0B00);
        wr(3'd3, 32'h0000_0000);
        @(negedge clk);
        frame_done = 2'b11;
        @(negedge clk);
        frame_done = '0;
        chk("R10 ch0 address", faddr(0), 32'h0000_0A00);
        chk("R10 ch1 address", faddr(1), 32'h0000_0B00);
        load(0);
        chk("R10 ch1 still pending", {30'h0, fetch_req}, 32'h2);
        load(1);
        chk("R10 both released", {30'h0, fetch_req}, 32'h0);

        // R10: activity on ch1 leaves ch0's request alone
        wr(3'd1, 32'h0000_0C01);
        wr(3'd3, 32'h0000_0D03);
        frame_end(1);
        load(1);
        rd(3'd1, d);
        chk("R10 ch0 request untouched", d, 32'h0000_0C01);
        rd(3'd4, d);
        chk("R10 only ch1 status", d, 32'h0000_0008);
        chk("R10 ch0 idle", {31'h0, fetch_req[0]}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule